// File: doc/BRIEF.md
# Byte-Lane Access Qualifier

This block sits between a PCI target sequencer and the registers of the function behind it. For each decoded bus request it answers four questions. Is the request claimed at all? Which address window does it fall in? Should it actually touch a register, or complete on the bus as a harmless no-op? Which register index and which byte lane does it concern? The block holds the four base-address registers and a 2-bit lane-select control word, and serves configuration accesses to them directly.

Two kinds of window exist. Byte windows hold one 8-bit register per slot. In I/O space a slot is one byte, and the single enabled lane must agree with the low address bits. In memory space every byte register takes a whole DWORD, and software chooses the valid lane so that big-endian hosts can use the block without swapping bytes. Local windows and configuration space take any byte-enable pattern. A request whose byte enables do not qualify is still reported as a hit, so the sequencer completes it normally, but it is flagged as not effective.

Each request is presented for one cycle with `req_valid`. The response appears on the next clock edge and lasts one cycle. Read data for function windows is formed from the function's own read inputs in the response cycle.

Top module: `byte_lane_qual`

## Requirements
- R1: `req_kind` encodes 0 = configuration (target already selected), 1 = I/O, 2 = memory, 3 = any other cycle. An I/O request is claimed only inside window 0 (I/O byte) or window 1 (I/O local), and a memory request only inside window 2 (memory byte) or window 3 (memory local). A request is inside a window when its address bits above the window size equal the stored base. Kind 3 and unmatched addresses give hit 0 and region 0. Region codes: 1 I/O byte, 2 I/O local, 3 memory byte, 4 memory local, 5 configuration.
- R2: In the I/O byte window a request is effective only when `req_be` equals exactly `1 << addr[1:0]`. The index is the address offset inside the window, byte granular. For an effective write, `rsp_byte` is the write data on lane `addr[1:0]`.
- R3: A hit that is not effective still reports hit 1, region and index, but gives `rsp_effective` 0, `rsp_be` 0, `rsp_byte` 0 and `rsp_rdata` 0.
- R4: In the memory byte window each register takes one DWORD, and the index is the window offset with bits [1:0] dropped.
- R5: In the memory byte window a request is effective only when `req_be` equals `1 << lane_select`. For an effective write, `rsp_byte` is the write data on that lane. A change of lane select applies to the next request.
- R6: Local windows are effective for every byte-enable pattern, including none. `rsp_be` equals `req_be`, the index is the window offset in DWORDs, `rsp_byte` is 0, and read data is `fn_rword` with disabled lanes forced to zero.
- R7: Configuration requests are always hit and effective, with region 5 and index 0. A configuration write changes only enabled bytes. A configuration read returns zero on disabled lanes.
- R8: The configuration map is: DWORD offsets 4 to 7 (byte addresses 0x10 to 0x1C) hold bases 0 to 3, and offset 16 (0x40) holds lane select in bits [1:0], with all other bits reading 0. Writes to any other offset change nothing, and reads of them return 0.
- R9: A base write keeps only the bits at or above the window size. Bit 0 reads back 1 for I/O windows and 0 for memory windows, and the bits between read back 0.
- R10: An effective read in a byte window returns `fn_rbyte` on the qualifying lane and zeros on the other three lanes.
- R11: `rsp_valid` is `req_valid` delayed by one clock. Without a request, hit, effective and all data outputs are 0. After reset the bases are 0 and lane select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Cycle kind: 0 config, 1 I/O, 2 memory, 3 other |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Bus address; config uses bits [7:2] as DWORD offset |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| fn_rbyte | input | 8 | Function register byte for the indexed byte register |
| fn_rword | input | 32 | Function register word for the indexed local register |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request claimed |
| rsp_effective | output | 1 | Request may act on a register |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_region | output | 3 | Region code per R1 |
| rsp_index | output | IDXW | Register index inside the window |
| rsp_be | output | 4 | Qualified byte lanes |
| rsp_byte | output | 8 | Write byte extracted from the qualifying lane |
| rsp_rdata | output | 32 | Read data, zero on unqualified lanes |

## Verification
Every piece of internal state here (a base or the lane select) shows up at the ports within two requests. A wrong stored base changes the hit flag on the next access near the window edge, and it also shows in a configuration read of that base. A wrong lane select turns the matching memory byte access into a no-op, and a byte on some other lane becomes effective in its place. The checks therefore pair each configuration write with a readback and with accesses on both sides of every window limit and on both the right and the wrong lane. The first wrong response is visible one clock after the faulty request.

// File: rtl/blq_pkg.sv
package blq_pkg;

  localparam int NBARS = 4;

  typedef enum logic [1:0] {
    KIND_CFG   = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MEM   = 2'd2,
    KIND_OTHER = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    RG_NONE      = 3'd0,
    RG_IO_BYTE   = 3'd1,
    RG_IO_LOCAL  = 3'd2,
    RG_MEM_BYTE  = 3'd3,
    RG_MEM_LOCAL = 3'd4,
    RG_CFG       = 3'd5
  } region_e;

  localparam logic [5:0] CFG_BAR_FIRST = 6'd4;
  localparam logic [5:0] CFG_LANE_OFF  = 6'd16;

  function automatic logic bar_is_mem(int i);
    return i >= 2;
  endfunction

  function automatic region_e bar_region(int i);
    case (i)
      0:       return RG_IO_BYTE;
      1:       return RG_IO_LOCAL;
      2:       return RG_MEM_BYTE;
      default: return RG_MEM_LOCAL;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Bits at or above the window size.
  function automatic logic [31:0] size_mask(int unsigned aw);
    return ~((32'd1 << aw) - 32'd1);
  endfunction

  // Expand byte enables into a 32-bit lane mask.
  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
    return m;
  endfunction

  function automatic logic [3:0] lane_bit(logic [1:0] l);
    return 4'b0001 << l;
  endfunction

  function automatic logic [7:0] get_byte(logic [31:0] d, logic [1:0] l);
    return d[{l, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] put_byte(logic [7:0] b, logic [1:0] l);
    return {24'd0, b} << {l, 3'b000};
  endfunction

  function automatic logic [31:0] merge_bytes(logic [31:0] old_v, logic [31:0] new_v,
                                              logic [3:0] be);
    return (old_v & ~lane_mask(be)) | (new_v & lane_mask(be));
  endfunction

  // Readback of a base: stored high bits plus the space flag in bit 0.
  function automatic logic [31:0] bar_view(logic [31:0] base, int unsigned aw, logic is_mem);
    return (base & size_mask(aw)) | {31'd0, ~is_mem};
  endfunction

endpackage

// File: rtl/blq_cfg_space.sv
module blq_cfg_space
  import blq_pkg::*;
#(
  parameter int unsigned IO_BYTE_AW   = 3,
  parameter int unsigned IO_LOCAL_AW  = 4,
  parameter int unsigned MEM_BYTE_AW  = 5,
  parameter int unsigned MEM_LOCAL_AW = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [5:0]                  cfg_off,
  input  logic [3:0]                  cfg_be,
  input  logic [31:0]                 cfg_wdata,
  output logic [NBARS-1:0][31:0]      bar_base,
  output logic [1:0]                  lane_sel,
  output logic [31:0]                 cfg_rdata
);

  localparam int unsigned BAR_AW [NBARS] = '{IO_BYTE_AW, IO_LOCAL_AW, MEM_BYTE_AW, MEM_LOCAL_AW};

  logic [NBARS-1:0]       bar_sel;
  logic [NBARS-1:0][31:0] bar_rd;
  logic                   lane_hit;
  logic [1:0]             lane_q;

  for (genvar g = 0; g < NBARS; g++) begin : g_bar
    logic [31:0] base_q;
    assign bar_sel[g] = (cfg_off == CFG_BAR_FIRST + 6'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) base_q <= '0;
      else if (cfg_we && bar_sel[g])
        base_q <= merge_bytes(base_q, cfg_wdata, cfg_be) & size_mask(BAR_AW[g]);
    end
    assign bar_base[g] = base_q;
    assign bar_rd[g]   = bar_view(base_q, BAR_AW[g], bar_is_mem(g));
  end

  assign lane_hit = (cfg_off == CFG_LANE_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) lane_q <= 2'd0;
    else if (cfg_we && lane_hit && cfg_be[0]) lane_q <= cfg_wdata[1:0];
  end

  assign lane_sel = lane_q;

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NBARS; i++)
      if (bar_sel[i]) cfg_rdata = bar_rd[i];
    if (lane_hit) cfg_rdata = {30'd0, lane_q};
  end

endmodule

// File: rtl/blq_region_decode.sv
module blq_region_decode
  import blq_pkg::*;
#(
  parameter int unsigned IO_BYTE_AW   = 3,
  parameter int unsigned IO_LOCAL_AW  = 4,
  parameter int unsigned MEM_BYTE_AW  = 5,
  parameter int unsigned MEM_LOCAL_AW = 6
) (
  input  kind_e                  kind,
  input  logic [31:0]            addr,
  input  logic [NBARS-1:0][31:0] bar_base,
  output logic                   hit,
  output region_e                region
);

  localparam int unsigned BAR_AW [NBARS] = '{IO_BYTE_AW, IO_LOCAL_AW, MEM_BYTE_AW, MEM_LOCAL_AW};

  logic want_mem;
  assign want_mem = (kind == KIND_MEM);

  // Descending scan: the lowest matching window wins.
  always_comb begin
    hit    = 1'b0;
    region = RG_NONE;
    if (kind == KIND_CFG) begin
      hit    = 1'b1;
      region = RG_CFG;
    end else if (kind == KIND_IO || kind == KIND_MEM) begin
      for (int i = NBARS - 1; i >= 0; i--) begin
        if (bar_is_mem(i) == want_mem &&
            (addr & size_mask(BAR_AW[i])) == bar_base[i]) begin
          hit    = 1'b1;
          region = bar_region(i);
        end
      end
    end
  end

endmodule

// File: rtl/blq_lane_gate.sv
module blq_lane_gate
  import blq_pkg::*;
#(
  parameter int unsigned IO_BYTE_AW   = 3,
  parameter int unsigned IO_LOCAL_AW  = 4,
  parameter int unsigned MEM_BYTE_AW  = 5,
  parameter int unsigned MEM_LOCAL_AW = 6,
  parameter int unsigned IDXW         = 4,
  parameter int unsigned LOWW         = 6
) (
  input  region_e          region,
  input  logic [LOWW-1:0]  addr_lo,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic             write,
  input  logic [1:0]       lane_sel,
  output logic             effective,
  output logic [3:0]       qual_be,
  output logic [IDXW-1:0]  index,
  output logic [7:0]       wbyte,
  output logic [1:0]       rd_lane
);

  logic byte_win;
  assign byte_win = (region == RG_IO_BYTE) || (region == RG_MEM_BYTE);

  always_comb begin
    effective = 1'b0;
    index     = '0;
    rd_lane   = 2'd0;
    case (region)
      RG_IO_BYTE: begin
        rd_lane   = addr_lo[1:0];
        effective = (be == lane_bit(addr_lo[1:0]));
        index     = IDXW'(addr_lo[IO_BYTE_AW-1:0]);
      end
      RG_MEM_BYTE: begin
        rd_lane   = lane_sel;
        effective = (be == lane_bit(lane_sel));
        index     = IDXW'(addr_lo[MEM_BYTE_AW-1:2]);
      end
      RG_IO_LOCAL: begin
        effective = 1'b1;
        index     = IDXW'(addr_lo[IO_LOCAL_AW-1:2]);
      end
      RG_MEM_LOCAL: begin
        effective = 1'b1;
        index     = IDXW'(addr_lo[MEM_LOCAL_AW-1:2]);
      end
      RG_CFG:  effective = 1'b1;
      default: effective = 1'b0;
    endcase
  end

  assign qual_be = effective ? be : 4'd0;
  assign wbyte   = (effective && write && byte_win) ? get_byte(wdata, rd_lane) : 8'd0;

endmodule

// File: rtl/byte_lane_qual.sv
module byte_lane_qual
  import blq_pkg::*;
#(
  parameter int unsigned IO_BYTE_AW   = 3,
  parameter int unsigned IO_LOCAL_AW  = 4,
  parameter int unsigned MEM_BYTE_AW  = 5,
  parameter int unsigned MEM_LOCAL_AW = 6,
  localparam int unsigned IDXW = max4(IO_BYTE_AW, IO_LOCAL_AW - 2,
                                      MEM_BYTE_AW - 2, MEM_LOCAL_AW - 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  input  logic [7:0]       fn_rbyte,
  input  logic [31:0]      fn_rword,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_effective,
  output logic             rsp_write,
  output logic [2:0]       rsp_region,
  output logic [IDXW-1:0]  rsp_index,
  output logic [3:0]       rsp_be,
  output logic [7:0]       rsp_byte,
  output logic [31:0]      rsp_rdata
);

  localparam int unsigned LOWW = max4(IO_BYTE_AW, IO_LOCAL_AW, MEM_BYTE_AW, MEM_LOCAL_AW);

  kind_e                  kind;
  logic                   cfg_we;
  logic [NBARS-1:0][31:0] bar_base;
  logic [1:0]             lane_sel;
  logic [31:0]            cfg_rdata;
  logic                   dec_hit;
  region_e                dec_region;
  logic                   gate_eff;
  logic [3:0]             gate_be;
  logic [IDXW-1:0]        gate_index;
  logic [7:0]             gate_wbyte;
  logic [1:0]             gate_lane;

  assign kind   = kind_e'(req_kind);
  assign cfg_we = req_valid && (kind == KIND_CFG) && req_write;

  blq_cfg_space #(
    .IO_BYTE_AW(IO_BYTE_AW), .IO_LOCAL_AW(IO_LOCAL_AW),
    .MEM_BYTE_AW(MEM_BYTE_AW), .MEM_LOCAL_AW(MEM_LOCAL_AW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(req_addr[7:2]),
    .cfg_be(req_be), .cfg_wdata(req_wdata), .bar_base(bar_base),
    .lane_sel(lane_sel), .cfg_rdata(cfg_rdata)
  );

  blq_region_decode #(
    .IO_BYTE_AW(IO_BYTE_AW), .IO_LOCAL_AW(IO_LOCAL_AW),
    .MEM_BYTE_AW(MEM_BYTE_AW), .MEM_LOCAL_AW(MEM_LOCAL_AW)
  ) u_dec (
    .kind(kind), .addr(req_addr), .bar_base(bar_base),
    .hit(dec_hit), .region(dec_region)
  );

  blq_lane_gate #(
    .IO_BYTE_AW(IO_BYTE_AW), .IO_LOCAL_AW(IO_LOCAL_AW),
    .MEM_BYTE_AW(MEM_BYTE_AW), .MEM_LOCAL_AW(MEM_LOCAL_AW),
    .IDXW(IDXW), .LOWW(LOWW)
  ) u_gate (
    .region(dec_region), .addr_lo(req_addr[LOWW-1:0]), .be(req_be),
    .wdata(req_wdata), .write(req_write), .lane_sel(lane_sel),
    .effective(gate_eff), .qual_be(gate_be), .index(gate_index),
    .wbyte(gate_wbyte), .rd_lane(gate_lane)
  );

  // Response stage
  logic            valid_q, hit_q, eff_q, write_q;
  region_e         region_q;
  logic [IDXW-1:0] index_q;
  logic [3:0]      be_q;
  logic [7:0]      byte_q;
  logic [1:0]      lane_q;
  logic [31:0]     cfg_rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      eff_q    <= 1'b0;
      write_q  <= 1'b0;
      region_q <= RG_NONE;
      index_q  <= '0;
      be_q     <= 4'd0;
      byte_q   <= 8'd0;
      lane_q   <= 2'd0;
      cfg_rd_q <= '0;
    end else begin
      valid_q  <= 1'b1;
      hit_q    <= dec_hit;
      eff_q    <= gate_eff;
      write_q  <= req_write;
      region_q <= dec_region;
      index_q  <= (dec_region == RG_CFG) ? '0 : gate_index;
      be_q     <= gate_be;
      byte_q   <= gate_wbyte;
      lane_q   <= gate_lane;
      cfg_rd_q <= (kind == KIND_CFG && !req_write) ? (cfg_rdata & lane_mask(req_be)) : '0;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (valid_q && eff_q && !write_q) begin
      case (region_q)
        RG_CFG:                   rsp_rdata = cfg_rd_q;
        RG_IO_BYTE, RG_MEM_BYTE:  rsp_rdata = put_byte(fn_rbyte, lane_q);
        RG_IO_LOCAL, RG_MEM_LOCAL: rsp_rdata = fn_rword & lane_mask(be_q);
        default:                  rsp_rdata = '0;
      endcase
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_hit       = hit_q;
  assign rsp_effective = eff_q;
  assign rsp_write     = write_q;
  assign rsp_region    = region_q;
  assign rsp_index     = index_q;
  assign rsp_be        = be_q;
  assign rsp_byte      = byte_q;

endmodule

// File: rtl/blq_checker.sv
module blq_checker
  import blq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_effective,
  input logic [2:0]  rsp_region,
  input logic [3:0]  rsp_be,
  input logic [7:0]  rsp_byte,
  input logic [31:0] rsp_rdata,
  input logic        dec_hit,
  input logic        gate_eff
);

  // R11
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_effective && rsp_rdata == 32'd0));

  // R3
  eff_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_effective |-> rsp_hit);

  // R3
  gate_needs_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_eff |-> dec_hit);

  // R3
  noeffect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_effective) |-> (rsp_be == 4'd0 && rsp_byte == 8'd0 && rsp_rdata == 32'd0));

  // R1
  miss_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_region == 3'd0);

  // R5
  byte_lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_effective && (rsp_region == 3'd1 || rsp_region == 3'd3)) |-> $onehot0(rsp_be) && rsp_be != 4'd0);

  // R10
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rdata & ~lane_mask(rsp_be)) == 32'd0);

endmodule

bind byte_lane_qual blq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_effective(rsp_effective), .rsp_region(rsp_region),
  .rsp_be(rsp_be), .rsp_byte(rsp_byte), .rsp_rdata(rsp_rdata),
  .dec_hit(dec_hit), .gate_eff(gate_eff)
);

// File: tb/test_byte_lane_qual.sv
module test_byte_lane_qual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  fn_rbyte = '0;
  logic [31:0] fn_rword = '0;
  logic        rsp_valid, rsp_hit, rsp_effective, rsp_write;
  logic [2:0]  rsp_region;
  logic [3:0]  rsp_index;
  logic [3:0]  rsp_be;
  logic [7:0]  rsp_byte;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_lane_qual i_byte_lane_qual (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .fn_rbyte(fn_rbyte), .fn_rword(fn_rword),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_effective(rsp_effective),
    .rsp_write(rsp_write), .rsp_region(rsp_region), .rsp_index(rsp_index),
    .rsp_be(rsp_be), .rsp_byte(rsp_byte), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [7:0]  fbyte;
    logic [31:0] fword;
    logic        e_hit;
    logic        e_eff;
    logic [2:0]  e_region;
    logic [3:0]  e_index;
    logic [3:0]  e_be;
    logic [7:0]  e_byte;
    logic [31:0] e_rdata;
  } vec_t;

  localparam int NV = 16;
  // Windows: I/O byte 0x1000 (8 B), I/O local 0x2000 (16 B),
  // memory byte 0x8000_0000 (32 B), memory local 0x9000_0000 (64 B); lane select 3.
  localparam vec_t VECS [NV] = '{
    // R2 matching lane, write
    '{2'd1, 1'b1, 32'h0000_1002, 4'b0100, 32'h00AB_0000, 8'h00, 32'h0, 1'b1, 1'b1, 3'd1, 4'd2, 4'b0100, 8'hAB, 32'h0},
    // R3 wrong lane in I/O byte window
    '{2'd1, 1'b1, 32'h0000_1002, 4'b0001, 32'h0000_00CD, 8'h00, 32'h0, 1'b1, 1'b0, 3'd1, 4'd2, 4'b0000, 8'h00, 32'h0},
    // R2 two lanes enabled is not effective
    '{2'd1, 1'b1, 32'h0000_1003, 4'b1100, 32'hFFFF_0000, 8'h00, 32'h0, 1'b1, 1'b0, 3'd1, 4'd3, 4'b0000, 8'h00, 32'h0},
    // R10 I/O byte read on lane 1
    '{2'd1, 1'b0, 32'h0000_1005, 4'b0010, 32'h0, 8'h5A, 32'h0, 1'b1, 1'b1, 3'd1, 4'd5, 4'b0010, 8'h00, 32'h0000_5A00},
    // R1 just past the I/O byte window
    '{2'd1, 1'b0, 32'h0000_1008, 4'b0001, 32'h0, 8'h11, 32'h0, 1'b0, 1'b0, 3'd0, 4'd0, 4'b0000, 8'h00, 32'h0},
    // R6 I/O local write, two middle lanes
    '{2'd1, 1'b1, 32'h0000_200C, 4'b0110, 32'h1122_3344, 8'h00, 32'h0, 1'b1, 1'b1, 3'd2, 4'd3, 4'b0110, 8'h00, 32'h0},
    // R6 I/O local read, outer lanes
    '{2'd1, 1'b0, 32'h0000_2004, 4'b1001, 32'h0, 8'h00, 32'hDEAD_BEEF, 1'b1, 1'b1, 3'd2, 4'd1, 4'b1001, 8'h00, 32'hDE00_00EF},
    // R1 memory kind into an I/O range
    '{2'd2, 1'b0, 32'h0000_1002, 4'b0100, 32'h0, 8'h00, 32'h0, 1'b0, 1'b0, 3'd0, 4'd0, 4'b0000, 8'h00, 32'h0},
    // R1 I/O kind into a memory range
    '{2'd1, 1'b0, 32'h8000_0004, 4'b1000, 32'h0, 8'h00, 32'h0, 1'b0, 1'b0, 3'd0, 4'd0, 4'b0000, 8'h00, 32'h0},
    // R4 R5 memory byte write on lane 3
    '{2'd2, 1'b1, 32'h8000_0014, 4'b1000, 32'h7700_0000, 8'h00, 32'h0, 1'b1, 1'b1, 3'd3, 4'd5, 4'b1000, 8'h77, 32'h0},
    // R5 R3 memory byte write on wrong lane
    '{2'd2, 1'b1, 32'h8000_0014, 4'b0001, 32'h0000_0077, 8'h00, 32'h0, 1'b1, 1'b0, 3'd3, 4'd5, 4'b0000, 8'h00, 32'h0},
    // R10 R4 memory byte read on lane 3
    '{2'd2, 1'b0, 32'h8000_001C, 4'b1000, 32'h0, 8'hC3, 32'h0, 1'b1, 1'b1, 3'd3, 4'd7, 4'b1000, 8'h00, 32'hC300_0000},
    // R6 memory local with no lanes enabled
    '{2'd2, 1'b1, 32'h9000_003C, 4'b0000, 32'hFFFF_FFFF, 8'h00, 32'h0, 1'b1, 1'b1, 3'd4, 4'd15, 4'b0000, 8'h00, 32'h0},
    // R6 memory local full read
    '{2'd2, 1'b0, 32'h9000_0020, 4'b1111, 32'h0, 8'h00, 32'h0123_4567, 1'b1, 1'b1, 3'd4, 4'd8, 4'b1111, 8'h00, 32'h0123_4567},
    // R1 other cycle kind ignored
    '{2'd3, 1'b0, 32'h8000_0000, 4'b1000, 32'h0, 8'h00, 32'h0, 1'b0, 1'b0, 3'd0, 4'd0, 4'b0000, 8'h00, 32'h0},
    // R1 just past the memory byte window
    '{2'd2, 1'b0, 32'h8000_0020, 4'b1000, 32'h0, 8'h00, 32'h0, 1'b0, 1'b0, 3'd0, 4'd0, 4'b0000, 8'h00, 32'h0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] kind, logic wr, logic [31:0] addr, logic [3:0] be,
                       logic [31:0] wd, logic [7:0] fb, logic [31:0] fw);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_write = wr; req_addr = addr;
    req_be = be; req_wdata = wd; fn_rbyte = fb; fn_rword = fw;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_wr(logic [5:0] off, logic [3:0] be, logic [31:0] d);
    issue(2'd0, 1'b1, {24'd0, off, 2'b00}, be, d, 8'h0, 32'h0);
  endtask

  task automatic cfg_rd_chk(string tag, logic [5:0] off, logic [3:0] be, logic [31:0] exp);
    issue(2'd0, 1'b0, {24'd0, off, 2'b00}, be, 32'h0, 8'h0, 32'h0);
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 valid low in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle hit low", {31'd0, rsp_hit}, 32'd0);

    // Reset values
    cfg_rd_chk("R11 reset io base", 6'd4, 4'b1111, 32'h0000_0001);
    cfg_rd_chk("R11 reset mem base", 6'd6, 4'b1111, 32'h0000_0000);
    cfg_rd_chk("R11 reset lane select", 6'd16, 4'b1111, 32'h0);
    chk("R7 cfg region", {29'd0, rsp_region}, 32'd5);
    chk("R7 cfg effective", {30'd0, rsp_hit, rsp_effective}, 32'd3);
    chk("R11 response one cycle", {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    chk("R11 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);

    // R9 size probes
    cfg_wr(6'd4, 4'b1111, 32'hFFFF_FFFF);
    cfg_rd_chk("R9 io byte probe", 6'd4, 4'b1111, 32'hFFFF_FFF9);
    cfg_wr(6'd6, 4'b1111, 32'hFFFF_FFFF);
    cfg_rd_chk("R9 mem byte probe", 6'd6, 4'b1111, 32'hFFFF_FFE0);

    // Program windows
    cfg_wr(6'd4, 4'b1111, 32'h0000_1007);
    cfg_wr(6'd5, 4'b1111, 32'h0000_2000);
    cfg_wr(6'd6, 4'b1111, 32'h8000_0000);
    cfg_wr(6'd7, 4'b1111, 32'h9000_0000);
    cfg_rd_chk("R9 io byte base", 6'd4, 4'b1111, 32'h0000_1001);
    cfg_rd_chk("R9 io local base", 6'd5, 4'b1111, 32'h0000_2001);
    cfg_rd_chk("R9 mem local base", 6'd7, 4'b1111, 32'h9000_0000);
    cfg_wr(6'd16, 4'b0001, 32'h0000_0003);
    cfg_rd_chk("R8 lane select readback", 6'd16, 4'b1111, 32'h3);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      issue(VECS[k].kind, VECS[k].wr, VECS[k].addr, VECS[k].be, VECS[k].wdata,
            VECS[k].fbyte, VECS[k].fword);
      chk($sformatf("vec %0d hit", k), {31'd0, rsp_hit}, {31'd0, VECS[k].e_hit});
      chk($sformatf("vec %0d effective", k), {31'd0, rsp_effective}, {31'd0, VECS[k].e_eff});
      chk($sformatf("vec %0d region", k), {29'd0, rsp_region}, {29'd0, VECS[k].e_region});
      chk($sformatf("vec %0d index", k), {28'd0, rsp_index}, {28'd0, VECS[k].e_index});
      chk($sformatf("vec %0d lanes", k), {28'd0, rsp_be}, {28'd0, VECS[k].e_be});
      chk($sformatf("vec %0d byte", k), {24'd0, rsp_byte}, {24'd0, VECS[k].e_byte});
      chk($sformatf("vec %0d rdata", k), rsp_rdata, VECS[k].e_rdata);
    end

    // R5 lane select moved to lane 0
    cfg_wr(6'd16, 4'b0001, 32'h0000_0000);
    issue(2'd2, 1'b1, 32'h8000_0000, 4'b0001, 32'h0000_00A5, 8'h0, 32'h0);
    chk("R5 lane0 effective", {31'd0, rsp_effective}, 32'd1);
    chk("R5 lane0 byte", {24'd0, rsp_byte}, 32'h0000_00A5);
    issue(2'd2, 1'b1, 32'h8000_0000, 4'b1000, 32'hA500_0000, 8'h0, 32'h0);
    chk("R5 old lane now ignored", {31'd0, rsp_effective}, 32'd0);
    chk("R5 old lane no byte", {24'd0, rsp_byte}, 32'd0);
    cfg_wr(6'd16, 4'b0001, 32'h0000_0001);
    issue(2'd2, 1'b0, 32'h8000_0004, 4'b0010, 32'h0, 8'h99, 32'h0);
    chk("R10 lane1 read", rsp_rdata, 32'h0000_9900);
    chk("R4 lane1 index", {28'd0, rsp_index}, 32'd1);

    // R8 lane select high bits and unimplemented offsets
    cfg_wr(6'd16, 4'b1111, 32'hFFFF_FFFE);
    cfg_rd_chk("R8 lane select width", 6'd16, 4'b1111, 32'h2);
    cfg_wr(6'd17, 4'b1111, 32'hFFFF_FFFF);
    cfg_rd_chk("R8 unimplemented reads zero", 6'd17, 4'b1111, 32'h0);
    cfg_wr(6'd0, 4'b1111, 32'h0000_0001);
    cfg_rd_chk("R8 write elsewhere leaves lane", 6'd16, 4'b1111, 32'h2);
    cfg_rd_chk("R8 unimplemented offset 0", 6'd0, 4'b1111, 32'h0);

    // R7 partial byte enables
    cfg_wr(6'd7, 4'b0100, 32'h0055_FFFF);
    cfg_rd_chk("R7 merged base", 6'd7, 4'b1111, 32'h9055_0000);
    cfg_rd_chk("R7 read lane 2 only", 6'd7, 4'b0100, 32'h0055_0000);
    cfg_rd_chk("R7 disabled lanes zero", 6'd5, 4'b1100, 32'h0000_0000);
    cfg_rd_chk("R7 low lanes of io base", 6'd5, 4'b0011, 32'h0000_2001);

    finish_run();
  end

endmodule